// File: doc/BRIEF.md
# Threshold-Interrupt Word FIFO

This block is a single-clock first-in first-out queue of 32-bit words with a small register interface driven by a plain write/read strobe. Words enter from one of three writers: a data-port register write, or either of two streaming sources. Words leave through one of two readers: a data-port register read, or a dedicated streaming pop port. Control bits pick the active writer and reader. Until the queue is enabled it holds nothing and accepts nothing.

Each side of the queue carries its own interrupt logic. The push side reports a push into a full queue, free space at or below a programmed level, and changes of the memory power state. The pop side reports a pop from an empty queue, a fill at or above a programmed level, and the same power-state changes. Every such event sets a sticky status bit, and software clears it by writing a one to that bit. Each side drives an interrupt request, and a control bit sends it to either of two request lines. A single count register gives the words available to pop, the free slots, and empty and full flags.

Register addresses, word-indexed on `reg_addr`: 0 control, 1 status, 2 push-side configuration, 3 pop-side configuration, 4 count, 5 data. Reads are combinational from `reg_addr`. Writes take effect at the clock edge on which `reg_wr` is high.

Top module: `pfifo_top`

## Requirements
- R1: After a synchronous active-low reset, the count register reads 0x0100_8000 when DEPTH is 256. The control, status, push-configuration, pop-configuration and data registers all read 0, and both interrupt lines are low.
- R2: Accepted words leave in the order they arrived. A data-port read (`reg_rd` with address 5) returns the oldest word in that same cycle, and that word is removed at the clock edge.
- R3: The count register holds the words available to pop in [8:0], the free slots (DEPTH minus available) in [24:16], the empty flag in bit 15 and the full flag in bit 31. All other bits are 0. The register reflects every push and pop from the cycle after the edge on which it was accepted.
- R4: A push while the queue is full is dropped, the stored words are unchanged, and status bit 2 is set from the following cycle.
- R5: A pop while the queue is empty returns 0, leaves the queue unchanged, and sets status bit 5 from the following cycle.
- R6: Status bits [7:2] are sticky. Writing address 1 clears exactly the bits written as 1. Bits [1:0] cannot be written. A set event in the same cycle as its clear leaves the bit set.
- R7: The push and pop configuration registers share one layout: bit 0 sleep enable, bit 1 sleep type, bit 2 overflow/underflow interrupt enable, bit 3 threshold enable, bit 4 sleep interrupt enable, and [24:16] a threshold. While push bit 3 is set, status bit 3 sets one cycle after any cycle in which free slots ≤ the push threshold. While pop bit 3 is set, status bit 6 sets one cycle after any cycle in which available words ≥ the pop threshold.
- R8: The push-side request is the OR of status bits 2, 3 and 4, each masked by push configuration bits 2, 3 and 4. The pop-side request is the OR of status bits 5, 6 and 7, each masked by pop configuration bits 2, 3 and 4. Control bit 3 routes the push-side request and control bit 4 routes the pop-side request, with 0 selecting `irq_host` and 1 selecting `irq_alt`.
- R9: When control bit 1 is 0, pushes come from data-port writes (address 5). When it is 1, pushes come from stream source 0 if control bit 5 is 0, or from stream source 1 if bit 5 is 1. The writers that are not selected have no effect.
- R10: When control bit 2 is 1, `ext_pop` pops the queue and data-port reads return the oldest word without removing it. When bit 2 is 0, `ext_pop` has no effect. `ext_pop_data` always shows the oldest word, or 0 when the queue is empty.
- R11: While control bit 0 (enable) is 0, pushes and pops are ignored and set no status. The queue reads empty from the cycle after an edge at which enable was 0.
- R12: An accepted push and an accepted pop in the same cycle leave the count unchanged, and both words stay in order. On an empty queue, that pop underflows and the push is stored. On a full queue, that push is dropped and the pop is taken.
- R13: Status [1:0] is the power state, and it reflects its inputs one cycle later. It is 0 (active) when neither side's sleep enable is set. Otherwise it is 1 (light sleep) while the queue holds data, 2 (deep sleep) when empty and no sleep-enabled side has sleep type 1, and 3 (shut down) when empty and some sleep-enabled side has sleep type 1. When the state changes, status bit 4 sets if push configuration bit 4 is set, and bit 7 sets if pop configuration bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at the data address) |
| reg_addr | input | 3 | Word-indexed register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| strm0_push | input | 1 | Stream source 0 push request |
| strm0_data | input | DATA_W | Stream source 0 word |
| strm1_push | input | 1 | Stream source 1 push request |
| strm1_data | input | DATA_W | Stream source 1 word |
| ext_pop | input | 1 | Stream pop request |
| ext_pop_data | output | DATA_W | Oldest word, 0 when empty |
| irq_host | output | 1 | Interrupt request line 0 |
| irq_alt | output | 1 | Interrupt request line 1 |

## Verification
Pop data on `reg_rdata` and `ext_pop_data` is due in the same cycle as the request. The bench therefore compares it after driving inputs and before the rising edge. The count register and queue contents change one edge after a request. Sticky status bits, the power state and the interrupt lines follow one edge after the count or configuration they depend on. A reference model in the bench is stepped once at every rising edge from the same inputs, and all registers and interrupt lines are compared against it after the following falling edge. Directed constant checks at fill, overflow, underflow and clear cover the corner cases.

// File: rtl/pfifo_pkg.sv
// Shared register addresses and field types for the word FIFO.
package pfifo_pkg;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_PUSHC = 3'd2;
    localparam logic [2:0] A_POPC  = 3'd3;
    localparam logic [2:0] A_COUNT = 3'd4;
    localparam logic [2:0] A_DATA  = 3'd5;

    localparam int unsigned THR_W = 9;

    // Control byte, bit 0 is the LSB (enable).
    typedef struct packed {
        logic s1_sel;     // bit 5: which stream source
        logic rt_pop;     // bit 4: pop-side request line
        logic rt_push;    // bit 3: push-side request line
        logic pop_ext;    // bit 2: pop from stream port
        logic push_strm;  // bit 1: push from stream source
        logic en;         // bit 0: queue enable
    } ctrl_t;

    // Per-side configuration.
    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic sint_en;
        logic thr_en;
        logic xflow_en;
        logic slp_type;
        logic slp_en;
    } side_cfg_t;

    typedef enum logic [1:0] {
        PM_ON    = 2'd0,
        PM_LIGHT = 2'd1,
        PM_DEEP  = 2'd2,
        PM_OFF   = 2'd3
    } pm_t;

    // Pack a side configuration into its register word.
    function automatic logic [31:0] from_side(input side_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[16 +: THR_W] = c.thr;
        w[4:0] = {c.sint_en, c.thr_en, c.xflow_en, c.slp_type, c.slp_en};
        return w;
    endfunction

endpackage

// File: rtl/pfifo_store.sv
// Word storage with read/write pointers and an occupancy counter.
// Assumes push and pop are already qualified by the enable; clr empties
// the queue. A push while full and a pop while empty are ignored here.
module pfifo_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [DATA_W-1:0]            push_data,
    input  logic                         pop,
    output logic [DATA_W-1:0]            head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp;
    logic [AW-1:0]     rp;
    logic              do_push;
    logic              do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rp];

    // Pointer and occupancy update; clear returns to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

endmodule

// File: rtl/pfifo_cfg.sv
// Holds the control register and the two per-side configuration
// registers. Assumes word-indexed addresses from pfifo_pkg.
module pfifo_cfg
    import pfifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    output ctrl_t            ctrl,
    output side_cfg_t [1:0]  side
);
    logic unused_bits;
    assign unused_bits = ^{wdata[31:25], wdata[15:6]};

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ctrl <= '0;
        else if (wr && addr == A_CTRL)    ctrl <= ctrl_t'(wdata[5:0]);
    end

    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam logic [2:0] MY_A = (s == 0) ? A_PUSHC : A_POPC;
        side_cfg_t sq;

        // Side configuration register write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sq <= '0;
            end else if (wr && addr == MY_A) begin
                sq.thr      <= wdata[16 +: THR_W];
                sq.sint_en  <= wdata[4];
                sq.thr_en   <= wdata[3];
                sq.xflow_en <= wdata[2];
                sq.slp_type <= wdata[1];
                sq.slp_en   <= wdata[0];
            end
        end
        assign side[s] = sq;
    end

endmodule

// File: rtl/pfifo_status.sv
// Sticky interrupt status, power state and per-side requests.
// Side 0 is push, side 1 is pop. Set events win over a same-cycle clear.
module pfifo_status
    import pfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  side_cfg_t [1:0]             cfg,
    input  logic [$clog2(DEPTH+1)-1:0]  count,
    input  logic                        empty,
    input  logic [1:0]                  xflow,
    input  logic                        clr_wr,
    input  logic [7:0]                  clr_mask,
    output logic [7:0]                  stat,
    output logic [1:0]                  side_irq
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0]    free;
    logic [1:0]       thr_hit;
    logic             slp_req;
    logic             slp_deep_off;
    pm_t              pm_nx;
    pm_t              pm_q;
    logic             pm_chg;
    logic [1:0][2:0]  flags;
    logic             unused_mask;

    assign unused_mask = ^clr_mask[1:0];
    assign free        = CW'(DEPTH) - count;

    // Threshold conditions from the current occupancy.
    always_comb begin
        thr_hit[0] = 32'(free)  <= 32'(cfg[0].thr);
        thr_hit[1] = 32'(count) >= 32'(cfg[1].thr);
    end

    // Next power state from the sleep settings and occupancy.
    always_comb begin
        slp_req      = cfg[0].slp_en | cfg[1].slp_en;
        slp_deep_off = (cfg[0].slp_en & cfg[0].slp_type) | (cfg[1].slp_en & cfg[1].slp_type);
        if (!slp_req)          pm_nx = PM_ON;
        else if (!empty)       pm_nx = PM_LIGHT;
        else if (slp_deep_off) pm_nx = PM_OFF;
        else                   pm_nx = PM_DEEP;
    end

    assign pm_chg = (pm_nx != pm_q);

    // Power state register.
    always_ff @(posedge clk) begin
        if (!rst_n) pm_q <= PM_ON;
        else        pm_q <= pm_nx;
    end

    for (genvar s = 0; s < 2; s++) begin : g_side
        logic [2:0] fl_q;
        logic [2:0] set_v;
        logic [2:0] clr_v;

        // Set and clear vectors for this side.
        always_comb begin
            set_v = {pm_chg & cfg[s].sint_en, thr_hit[s] & cfg[s].thr_en, xflow[s]};
            clr_v = clr_wr ? clr_mask[2 + 3*s +: 3] : 3'b000;
        end

        // Sticky flags, write-one-to-clear.
        always_ff @(posedge clk) begin
            if (!rst_n) fl_q <= '0;
            else        fl_q <= (fl_q & ~clr_v) | set_v;
        end

        assign flags[s]    = fl_q;
        assign side_irq[s] = |(fl_q & {cfg[s].sint_en, cfg[s].thr_en, cfg[s].xflow_en});
    end

    assign stat = {flags, 2'(pm_q)};

endmodule

// File: rtl/pfifo_top.sv
// Word FIFO with register access, source/destination selection and
// per-side threshold, overflow/underflow and sleep interrupts.
// Assumes DATA_W <= 32 and DEPTH <= 511 (9-bit count fields).
module pfifo_top
    import pfifo_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              strm0_push,
    input  logic [DATA_W-1:0] strm0_data,
    input  logic              strm1_push,
    input  logic [DATA_W-1:0] strm1_data,
    input  logic              ext_pop,
    output logic [DATA_W-1:0] ext_pop_data,
    output logic              irq_host,
    output logic              irq_alt
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    ctrl_t            ctrl;
    side_cfg_t [1:0]  side;
    logic [7:0]       stat;
    logic [1:0]       side_irq;
    logic [DATA_W-1:0] head;
    logic [DATA_W-1:0] push_word;
    logic [CW-1:0]    count;
    logic [CW-1:0]    free;
    logic             full;
    logic             empty;
    logic             push_req;
    logic             pop_req;
    logic             clr_wr;
    logic [31:0]      count_word;

    pfifo_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .ctrl  (ctrl),
        .side  (side)
    );

    // Writer and reader selection, qualified by the enable.
    always_comb begin
        if (ctrl.push_strm) begin
            push_req  = ctrl.s1_sel ? strm1_push : strm0_push;
            push_word = ctrl.s1_sel ? strm1_data : strm0_data;
        end else begin
            push_req  = reg_wr && (reg_addr == A_DATA);
            push_word = reg_wdata[DATA_W-1:0];
        end
        push_req = push_req && ctrl.en;
        pop_req  = ctrl.en && (ctrl.pop_ext ? ext_pop : (reg_rd && (reg_addr == A_DATA)));
    end

    pfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!ctrl.en),
        .push      (push_req),
        .push_data (push_word),
        .pop       (pop_req),
        .head      (head),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    assign clr_wr = reg_wr && (reg_addr == A_STAT);

    pfifo_status #(.DEPTH(DEPTH)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (side),
        .count    (count),
        .empty    (empty),
        .xflow    ({pop_req & empty, push_req & full}),
        .clr_wr   (clr_wr),
        .clr_mask (reg_wdata[7:0]),
        .stat     (stat),
        .side_irq (side_irq)
    );

    assign free       = CW'(DEPTH) - count;
    assign count_word = {full, 6'b0, 9'(free), empty, 6'b0, 9'(count)};

    // Interrupt line routing.
    assign irq_host = (side_irq[0] & ~ctrl.rt_push) | (side_irq[1] & ~ctrl.rt_pop);
    assign irq_alt  = (side_irq[0] &  ctrl.rt_push) | (side_irq[1] &  ctrl.rt_pop);

    assign ext_pop_data = head;

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {26'b0, ctrl};
            A_STAT:  reg_rdata = {24'b0, stat};
            A_PUSHC: reg_rdata = from_side(side[0]);
            A_POPC:  reg_rdata = from_side(side[1]);
            A_COUNT: reg_rdata = count_word;
            A_DATA:  reg_rdata = 32'(head);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pfifo_chk.sv
// Property checker for pfifo_top, attached by bind.
module pfifo_chk #(
    parameter int unsigned DEPTH = 256
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        push_req,
    input logic                        pop_req,
    input logic                        full,
    input logic                        empty,
    input logic [$clog2(DEPTH+1)-1:0]  count,
    input logic [7:0]                  stat,
    input logic                        ctrl_en,
    input logic                        clr_wr,
    input logic [31:0]                 reg_wdata,
    input logic [31:0]                 ext_pop_data
);
    // R4: overflow raises its status bit.
    p_overflow_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> stat[2]);

    // R4: a dropped push leaves the occupancy alone.
    p_overflow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop_req) |=> $stable(count));

    // R5: underflow raises its status bit.
    p_underflow_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |=> stat[5]);

    // R5: nothing but zero is shown when empty.
    p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (ext_pop_data == 32'h0));

    // R12: paired push and pop keep the count.
    p_pair_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !full && !empty) |=> $stable(count));

    // R11: disabled queue is emptied.
    p_disable_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> (count == '0));

    // R6: sticky bit survives without a clearing write.
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[5] && !(clr_wr && reg_wdata[5])) |=> stat[5]);

endmodule

bind pfifo_top pfifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_req     (push_req),
    .pop_req      (pop_req),
    .full         (full),
    .empty        (empty),
    .count        (count),
    .stat         (stat),
    .ctrl_en      (ctrl.en),
    .clr_wr       (clr_wr),
    .reg_wdata    (reg_wdata),
    .ext_pop_data (32'(ext_pop_data))
);

// File: tb/sim_pfifo_top.sv
module sim_pfifo_top;
    localparam int D = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        strm0_push = 1'b0, strm1_push = 1'b0, ext_pop = 1'b0;
    logic [31:0] strm0_data = '0, strm1_data = '0;
    logic [31:0] ext_pop_data;
    logic        irq_host, irq_alt;

    always #10 clk = ~clk;

    pfifo_top #(.DATA_W(32), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .strm0_push(strm0_push), .strm0_data(strm0_data),
        .strm1_push(strm1_push), .strm1_data(strm1_data),
        .ext_pop(ext_pop), .ext_pop_data(ext_pop_data),
        .irq_host(irq_host), .irq_alt(irq_alt)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string cur = "R1";

    // Reference model state.
    logic [31:0] mq[$];
    logic [5:0]  m_ctrl = '0;
    logic [31:0] m_side [2] = '{32'h0, 32'h0};
    logic [5:0]  m_flags = '0;
    logic [1:0]  m_pm = '0;

    function automatic logic [31:0] exp_count();
        int c = mq.size();
        return {c == D, 6'b0, 9'(D - c), c == 0, 6'b0, 9'(c)};
    endfunction

    function automatic logic [31:0] exp_head();
        return (mq.size() > 0) ? mq[0] : 32'h0;
    endfunction

    function automatic logic side_irq(int s);
        logic [2:0] f = m_flags[3*s +: 3];
        logic [2:0] e = {m_side[s][4], m_side[s][3], m_side[s][2]};
        return |(f & e);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic peek(logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // Step the model by one clock edge with the inputs of that cycle.
    task automatic model_step(logic wr, logic rd, logic [2:0] a, logic [31:0] wd,
                              logic s0, logic [31:0] s0d, logic s1, logic [31:0] s1d, logic xp);
        int c = mq.size();
        logic full = (c == D), empty = (c == 0), en = m_ctrl[0];
        logic push, pop, req, typ, chg;
        logic [31:0] pd;
        logic [1:0] pmn;
        logic [5:0] setv, clrv;
        push = en && (m_ctrl[1] ? (m_ctrl[5] ? s1 : s0) : (wr && a == 3'd5));
        pd   = m_ctrl[1] ? (m_ctrl[5] ? s1d : s0d) : wd;
        pop  = en && (m_ctrl[2] ? xp : (rd && a == 3'd5));
        req  = m_side[0][0] | m_side[1][0];
        typ  = (m_side[0][0] & m_side[0][1]) | (m_side[1][0] & m_side[1][1]);
        pmn  = !req ? 2'd0 : !empty ? 2'd1 : typ ? 2'd3 : 2'd2;
        chg  = (pmn != m_pm);
        setv = {chg & m_side[1][4], (c >= int'(m_side[1][24:16])) & m_side[1][3], pop & empty,
                chg & m_side[0][4], ((D - c) <= int'(m_side[0][24:16])) & m_side[0][3], push & full};
        clrv = (wr && a == 3'd1) ? wd[7:2] : 6'b0;
        m_flags = (m_flags & ~clrv) | setv;
        m_pm = pmn;
        if (!en) mq.delete();
        else begin
            if (pop && !empty) void'(mq.pop_front());
            if (push && !full) mq.push_back(pd);
        end
        if (wr && a == 3'd0) m_ctrl = wd[5:0];
        if (wr && a == 3'd2) m_side[0] = wd & 32'h01FF_001F;
        if (wr && a == 3'd3) m_side[1] = wd & 32'h01FF_001F;
    endtask

    // One clock cycle: drive, check same-cycle data, step, check registers.
    task automatic cyc(logic wr, logic rd, logic [2:0] a, logic [31:0] wd,
                       logic s0, logic [31:0] s0d, logic s1, logic [31:0] s1d, logic xp);
        logic [31:0] v;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        strm0_push = s0; strm0_data = s0d; strm1_push = s1; strm1_data = s1d; ext_pop = xp;
        #1;
        if (rd && a == 3'd5) chk(cur, "pop data", reg_rdata, exp_head());
        chk(cur, "stream head", ext_pop_data, exp_head());
        @(posedge clk);
        model_step(wr, rd, a, wd, s0, s0d, s1, s1d, xp);
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; strm0_push = 0; strm1_push = 0; ext_pop = 0;
        peek(3'd4, v); chk(cur, "count reg", v, exp_count());
        peek(3'd1, v); chk(cur, "status reg", v, {24'b0, m_flags, m_pm});
        chk(cur, "irq_host", 32'(irq_host),
            32'((side_irq(0) & ~m_ctrl[3]) | (side_irq(1) & ~m_ctrl[4])));
        chk(cur, "irq_alt", 32'(irq_alt),
            32'((side_irq(0) & m_ctrl[3]) | (side_irq(1) & m_ctrl[4])));
    endtask

    task automatic wreg(logic [2:0] a, logic [31:0] d);
        cyc(1, 0, a, d, 0, 0, 0, 0, 0);
    endtask

    task automatic rpop();
        cyc(0, 1, 3'd5, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic idle();
        cyc(0, 0, 3'd0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        cur = "R1";
        peek(3'd0, v); chk("R1", "ctrl", v, 32'h0);
        peek(3'd1, v); chk("R1", "status", v, 32'h0);
        peek(3'd2, v); chk("R1", "push cfg", v, 32'h0);
        peek(3'd3, v); chk("R1", "pop cfg", v, 32'h0);
        peek(3'd4, v); chk("R1", "count", v, 32'h0100_8000);
        peek(3'd5, v); chk("R1", "data", v, 32'h0);
        chk("R1", "irqs", {30'b0, irq_alt, irq_host}, 32'h0);

        // R11: disabled queue ignores pushes and pops
        cur = "R11";
        for (int i = 0; i < 3; i++) wreg(3'd5, 32'h1111_0000 + i);
        rpop();
        peek(3'd4, v); chk("R11", "count while disabled", v, 32'h0100_8000);
        peek(3'd1, v); chk("R11", "no status while disabled", v, 32'h0);
        wreg(3'd0, 32'h1);

        // R2, R3: ordered push and pop through the data port
        cur = "R3";
        for (int i = 0; i < 5; i++) wreg(3'd5, 32'hC0DE_0000 + i);
        peek(3'd4, v); chk("R3", "count after 5", v, 32'h00FB_0005);
        cur = "R2";
        for (int i = 0; i < 5; i++) rpop();

        // R4, R12: fill, overflow, paired operations at full
        cur = "R4";
        for (int i = 0; i < D; i++) wreg(3'd5, 32'hA000_0000 + i);
        peek(3'd4, v); chk("R4", "count when full", v, 32'h8000_0100);
        wreg(3'd5, 32'hDEAD_DEAD);
        peek(3'd1, v); chk("R4", "overflow bit", v & 32'h4, 32'h4);
        cur = "R12";
        cyc(1, 1, 3'd5, 32'hBEEF_0001, 0, 0, 0, 0, 0);
        peek(3'd4, v); chk("R12", "full pair count", v, 32'h0001_00FF);
        cyc(1, 1, 3'd5, 32'hBEEF_0002, 0, 0, 0, 0, 0);
        peek(3'd4, v); chk("R12", "pair keeps count", v, 32'h0001_00FF);
        cur = "R2";
        for (int i = 0; i < 255; i++) rpop();

        // R5: underflow
        cur = "R5";
        rpop();
        peek(3'd1, v); chk("R5", "underflow bit", v & 32'h20, 32'h20);
        cur = "R12";
        cyc(1, 1, 3'd5, 32'h5A5A_0001, 0, 0, 0, 0, 0);
        peek(3'd4, v); chk("R12", "empty pair stores push", v, 32'h00FF_0001);
        rpop();

        // R6: write-one-to-clear
        cur = "R6";
        wreg(3'd1, 32'h0000_0007);
        peek(3'd1, v); chk("R6", "clear bit 2 only", v, 32'h20);
        wreg(3'd1, 32'h0000_0000);
        peek(3'd1, v); chk("R6", "zero write keeps", v, 32'h20);
        wreg(3'd1, 32'h0000_00FC);
        peek(3'd1, v); chk("R6", "all cleared", v, 32'h0);

        // R7, R8: pop threshold and routing
        cur = "R7";
        wreg(3'd3, 32'h0003_0008);
        for (int i = 0; i < 3; i++) wreg(3'd5, 32'h7000_0000 + i);
        idle();
        peek(3'd1, v); chk("R7", "pop threshold bit", v & 32'h40, 32'h40);
        cur = "R8";
        chk("R8", "pop irq to host", 32'(irq_host), 32'h1);
        wreg(3'd0, 32'h11);
        idle();
        wreg(3'd2, 32'h0100_0008);
        idle();
        wreg(3'd1, 32'h0000_00FC);
        wreg(3'd3, 32'h0);
        wreg(3'd2, 32'h0);
        wreg(3'd1, 32'h0000_00FC);

        // R9: stream sources
        cur = "R9";
        wreg(3'd0, 32'h03);
        cyc(1, 0, 3'd5, 32'hFFFF_0000, 1, 32'h0500_0001, 1, 32'h0600_0001, 0);
        wreg(3'd0, 32'h23);
        cyc(0, 0, 3'd0, 0, 1, 32'h0500_0002, 1, 32'h0600_0002, 0);

        // R10: stream pop destination
        cur = "R10";
        cyc(0, 0, 3'd0, 0, 0, 0, 0, 0, 1);
        wreg(3'd0, 32'h05);
        rpop();
        for (int i = 0; i < 8; i++) cyc(0, 0, 3'd0, 0, 0, 0, 0, 0, 1);
        wreg(3'd0, 32'h01);

        // R13: power state and sleep interrupt
        cur = "R13";
        wreg(3'd1, 32'h0000_00FC);
        wreg(3'd2, 32'h0000_0011);
        idle();
        peek(3'd1, v); chk("R13", "deep sleep and flag", v, 32'h12);
        wreg(3'd3, 32'h0000_0003);
        idle();
        wreg(3'd5, 32'h3333_3333);
        idle();
        rpop();
        idle();
        wreg(3'd2, 32'h0); wreg(3'd3, 32'h0);
        idle();
        wreg(3'd1, 32'h0000_00FC);

        // Random mix against the model
        cur = "R2";
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 3)
                wreg(3'd0, ($urandom & 32'h3E) | (($urandom_range(0, 7) == 0) ? 32'h0 : 32'h1));
            else if (r < 6)
                wreg(3'($urandom_range(2, 3)), $urandom & 32'h01FF_001F);
            else if (r < 9)
                wreg(3'd1, $urandom);
            else
                cyc(1'($urandom), 1'($urandom), 3'd5, $urandom,
                    1'($urandom), $urandom, 1'($urandom), $urandom, 1'($urandom));
        end

        summary();
        $finish;
    end
endmodule